// File: doc/BRIEF.md
# Machine-Mode Control and Status Register File

This block holds the machine-level control and status registers of a 64-bit core that runs only in machine mode on physical memory. The core presents one access per cycle: a 12-bit register address, an operation code and a 64-bit operand. The block returns the current value of that register combinationally in the same cycle. Any write, set or clear takes effect at the next clock edge. Accesses never stall, so there is no back-pressure: the core may issue one access every cycle and the result is always final in the cycle it is asked for.

Besides the access port, the block runs the cycle and retired-instruction counters and compares the cycle count against a timer compare value. It records trap entry and return-from-trap, and it computes the address the core must jump to when a trap is taken. The core drives the trap and return pulses and the retire pulse as plain single-cycle strobes.

Top module: `mcsr_file`

## Requirements
- R1: Read-only identity registers: the ISA register (0x301) reads 0x8000_0000_0000_1504, which is base width code 2 in bits 63:62 and extension bits 2, 8, 10 and 12. The hart id (0xF14) reads 0. The vendor (0xF11), architecture (0xF12) and implementation (0xF13) ids read their parameter values.
- R2: In the status register (0x300), only bit 3 (global interrupt enable), bit 7 (previous enable), bits 12:11 (previous privilege), bit 17 (modify privilege) and bit 21 (timeout wait) are writable. Bits 33:32 always read 2. Every other bit reads 0, so writing all ones reads back 0x0000_0002_0022_1888. After reset, bits 12:11 read 3.
- R3: Exception delegation (0x302), interrupt delegation (0x303), counter enable (0x306) and trap value (0x343) read 0, accept writes without flagging them, and ignore the written data.
- R4: Operation code 0 reads only, 1 writes the operand, 2 ORs the operand into the register and 3 clears the operand's one bits. The result is visible from the cycle after the access.
- R5: `csr_illegal` is high in the same cycle for any access to an address not in this list. It is also high for an operation other than 0 to an address with bits 11:10 equal to 3. A flagged access changes no register.
- R6: The trap vector register (0x305) has a mode in bits 1:0: 0 is direct and 1 is vectored. Writing mode 2 or 3 keeps the old mode. When the resulting mode is vectored, base bits VEC_LSB-1:2 are forced to 0; by default VEC_LSB is 8.
- R7: `trap_target_o` is the vector base with bits 1:0 zero. When the mode is vectored and `trap_irq_i` is high, it is instead the base ORed with four times `trap_code_i`.
- R8: The cycle counter (0xB00) increments every clock while inhibit bit 0 is clear, and holds while that bit is set. A write to the counter wins over the increment in the same cycle. The timer alias (0xFC0) reads the same value as the cycle counter.
- R9: The retired counter (0xB02) increments on each cycle with `retire_i` high while inhibit bit 2 is clear. A write to the counter wins over a retire pulse in the same cycle.
- R10: The counter inhibit register (0x320) keeps only bits 0 and 2. All other bits read 0.
- R11: `timer_irq_o` is high exactly when the cycle counter is greater than or equal to the timer compare register (0x7C0). The compare register resets to all ones.
- R12: On `trap_i`, the block makes these updates at the next edge. The exception PC (0x341) takes `trap_pc_i` with bit 0 cleared. The cause register (0x342) takes `trap_irq_i` in bit 63 and the code in its low bits. The previous-enable bit takes the old enable bit, the enable bit clears and the previous privilege becomes 3. A trap wins over a register write in the same cycle.
- R13: On `mret_i` without a trap, the enable bit takes the previous-enable bit and the previous-enable bit becomes 1.
- R14: The exception PC always has bit 0 read as 0. The cause register keeps bit 63 and the low CAUSE_W bits (6 by default), and reads every other bit as 0. Scratch (0x340) is a plain 64-bit register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_op | input | 2 | Access operation: 0 read, 1 write, 2 set, 3 clear |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | 64 | Write, set or clear operand |
| csr_rdata | output | 64 | Current value of the addressed register |
| csr_illegal | output | 1 | Access is not allowed |
| retire_i | input | 1 | One instruction retired this cycle |
| trap_i | input | 1 | Trap taken this cycle |
| trap_irq_i | input | 1 | The trap is an interrupt |
| trap_code_i | input | CAUSE_W | Trap cause code |
| trap_pc_i | input | 64 | PC of the trapping instruction |
| mret_i | input | 1 | Return from trap this cycle |
| trap_target_o | output | 64 | Address to jump to on a trap |
| timer_irq_o | output | 1 | Timer interrupt pending |

## Verification
A field that holds a wrong value shows on `csr_rdata` in the first cycle it is addressed, and a counter that slips differs from the predicted count within one clock. A status-field update that is lost on trap entry or return is visible on the next read of the status register. A wrong vector base or mode appears at once on `trap_target_o` as soon as an interrupt cause is presented. A comparison error on the timer shows on `timer_irq_o` in the cycle after the compare value or the counter crosses the boundary.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
  localparam int XLEN = 64;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  localparam logic [11:0] A_STATUS   = 12'h300;
  localparam logic [11:0] A_ISA      = 12'h301;
  localparam logic [11:0] A_EDELEG   = 12'h302;
  localparam logic [11:0] A_IDELEG   = 12'h303;
  localparam logic [11:0] A_TVEC     = 12'h305;
  localparam logic [11:0] A_CNTEN    = 12'h306;
  localparam logic [11:0] A_INHIBIT  = 12'h320;
  localparam logic [11:0] A_SCRATCH  = 12'h340;
  localparam logic [11:0] A_EPC      = 12'h341;
  localparam logic [11:0] A_CAUSE    = 12'h342;
  localparam logic [11:0] A_TVAL     = 12'h343;
  localparam logic [11:0] A_TIMECMP  = 12'h7C0;
  localparam logic [11:0] A_CYCLE    = 12'hB00;
  localparam logic [11:0] A_INSTRET  = 12'hB02;
  localparam logic [11:0] A_VENDOR   = 12'hF11;
  localparam logic [11:0] A_ARCH     = 12'hF12;
  localparam logic [11:0] A_IMPL     = 12'hF13;
  localparam logic [11:0] A_HART     = 12'hF14;
  localparam logic [11:0] A_TIME     = 12'hFC0;

  // status field positions
  localparam int ST_IE   = 3;
  localparam int ST_PIE  = 7;
  localparam int ST_PP0  = 11;
  localparam int ST_PP1  = 12;
  localparam int ST_PRV  = 17;
  localparam int ST_TW   = 21;

  localparam logic [XLEN-1:0] ST_WMASK =
    (64'd1 << ST_IE) | (64'd1 << ST_PIE) | (64'd3 << ST_PP0) |
    (64'd1 << ST_PRV) | (64'd1 << ST_TW);
  localparam logic [XLEN-1:0] ST_FIXED = 64'd2 << 32;

  localparam logic [XLEN-1:0] ISA_VALUE =
    (64'd2 << 62) | (64'd1 << 2) | (64'd1 << 8) | (64'd1 << 10) | (64'd1 << 12);

  localparam logic [XLEN-1:0] INHIBIT_MASK = 64'h5;

  function automatic logic [XLEN-1:0] csr_apply(input logic [1:0] op,
                                                input logic [XLEN-1:0] cur,
                                                input logic [XLEN-1:0] opnd);
    case (csr_op_e'(op))
      OP_WRITE: csr_apply = opnd;
      OP_SET:   csr_apply = cur | opnd;
      OP_CLEAR: csr_apply = cur & ~opnd;
      default:  csr_apply = cur;
    endcase
  endfunction
endpackage

// File: rtl/mcsr_counter.sv
module mcsr_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         we,
  input  logic [W-1:0] wval,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (we)  cnt_q <= wval;
    else if (inc) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  // R8 R9: step by one when counting, hold otherwise, write wins
  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !we) |=> cnt_q == $past(cnt_q) + W'(1));
  a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !we) |=> $stable(cnt_q));
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> cnt_q == $past(wval));
endmodule

// File: rtl/mcsr_counters.sv
module mcsr_counters
  import mcsr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            retire_i,
  input  logic            we_cycle,
  input  logic            we_instret,
  input  logic            we_inhibit,
  input  logic            we_cmp,
  input  logic [XLEN-1:0] wval,
  output logic [XLEN-1:0] cycle_o,
  output logic [XLEN-1:0] instret_o,
  output logic [XLEN-1:0] inhibit_o,
  output logic [XLEN-1:0] timecmp_o,
  output logic            timer_irq_o
);
  logic [XLEN-1:0] inh_q;
  logic [XLEN-1:0] cmp_q;
  logic [1:0]      cnt_inc;
  logic [1:0]      cnt_we;
  logic [XLEN-1:0] cnt_val [2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inh_q <= '0;
      cmp_q <= '1;
    end else begin
      if (we_inhibit) inh_q <= wval & INHIBIT_MASK;
      if (we_cmp)     cmp_q <= wval;
    end
  end

  assign cnt_inc = {retire_i & ~inh_q[2], ~inh_q[0]};
  assign cnt_we  = {we_instret, we_cycle};

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    mcsr_counter #(.W(XLEN)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cnt_inc[g]),
      .we    (cnt_we[g]),
      .wval  (wval),
      .cnt_o (cnt_val[g])
    );
  end

  assign cycle_o     = cnt_val[0];
  assign instret_o   = cnt_val[1];
  assign inhibit_o   = inh_q;
  assign timecmp_o   = cmp_q;
  assign timer_irq_o = (cnt_val[0] >= cmp_q);

  // R10: inhibit keeps only its two defined bits
  a_r10_inhibit_bits: assert property (@(posedge clk) disable iff (!rst_n)
    we_inhibit |=> (inh_q & ~INHIBIT_MASK) == '0);
endmodule

// File: rtl/mcsr_tvec.sv
module mcsr_tvec
  import mcsr_pkg::*;
#(
  parameter int CAUSE_W = 6,
  parameter int VEC_LSB = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [XLEN-1:0]    wval,
  input  logic               trap_irq_i,
  input  logic [CAUSE_W-1:0] trap_code_i,
  output logic [XLEN-1:0]    tvec_o,
  output logic [XLEN-1:0]    target_o
);
  localparam logic [XLEN-1:0] VEC_LOW = {{(XLEN-VEC_LSB){1'b0}}, {VEC_LSB{1'b1}}};
  localparam logic [XLEN-1:0] DIR_LOW = 64'd3;

  logic [XLEN-1:0] base_q;
  logic            vec_q;
  logic            vec_n;

  always_comb begin
    vec_n = vec_q;
    if (wval[1] == 1'b0) vec_n = wval[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      vec_q  <= 1'b0;
    end else if (we) begin
      vec_q  <= vec_n;
      base_q <= wval & ~(vec_n ? VEC_LOW : DIR_LOW);
    end
  end

  assign tvec_o   = base_q | {{(XLEN-1){1'b0}}, vec_q};
  assign target_o = (vec_q && trap_irq_i)
                    ? (base_q | (XLEN'(trap_code_i) << 2))
                    : base_q;

  // R6: vectored base stays aligned so the cause can be ORed in
  a_r6_vec_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    vec_q |-> (base_q & VEC_LOW) == '0);
  // R6: a reserved mode value leaves the mode untouched
  a_r6_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wval[1]) |=> vec_q == $past(vec_q));
endmodule

// File: rtl/mcsr_status.sv
module mcsr_status
  import mcsr_pkg::*;
#(
  parameter int CAUSE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_status,
  input  logic               we_epc,
  input  logic               we_cause,
  input  logic [XLEN-1:0]    wval,
  input  logic               trap_i,
  input  logic               trap_irq_i,
  input  logic [CAUSE_W-1:0] trap_code_i,
  input  logic [XLEN-1:0]    trap_pc_i,
  input  logic               mret_i,
  output logic [XLEN-1:0]    status_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [XLEN-1:0]    cause_o
);
  localparam logic [XLEN-1:0] CAUSE_MASK =
    (64'd1 << (XLEN-1)) | ((64'd1 << CAUSE_W) - 64'd1);
  localparam logic [XLEN-1:0] EVEN_MASK = ~64'd1;

  logic [XLEN-1:0] st_q, st_n;
  logic [XLEN-1:0] epc_q, epc_n;
  logic [XLEN-1:0] cause_q, cause_n;

  always_comb begin
    st_n    = st_q;
    epc_n   = epc_q;
    cause_n = cause_q;
    if (trap_i) begin
      st_n[ST_PIE]          = st_q[ST_IE];
      st_n[ST_IE]           = 1'b0;
      st_n[ST_PP1:ST_PP0]   = 2'b11;
      epc_n                 = trap_pc_i & EVEN_MASK;
      cause_n               = (XLEN'(trap_irq_i) << (XLEN-1)) | XLEN'(trap_code_i);
    end else begin
      if (mret_i) begin
        st_n[ST_IE]  = st_q[ST_PIE];
        st_n[ST_PIE] = 1'b1;
      end else if (we_status) begin
        st_n = (wval & ST_WMASK) | ST_FIXED;
      end
      if (we_epc)   epc_n   = wval & EVEN_MASK;
      if (we_cause) cause_n = wval & CAUSE_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_FIXED | (64'd3 << ST_PP0);
      epc_q   <= '0;
      cause_q <= '0;
    end else begin
      st_q    <= st_n;
      epc_q   <= epc_n;
      cause_q <= cause_n;
    end
  end

  assign status_o = st_q;
  assign epc_o    = epc_q;
  assign cause_o  = cause_q;

  // R12: trap entry saves the enable, clears it and records privilege 3
  a_r12_trap_entry: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> !st_q[ST_IE] && st_q[ST_PP1:ST_PP0] == 2'b11
               && st_q[ST_PIE] == $past(st_q[ST_IE]));
  // R12 R14: trap PC captured with bit 0 cleared
  a_r12_trap_pc: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> epc_q == ($past(trap_pc_i) & EVEN_MASK));
  // R13: return restores the enable and sets the previous enable
  a_r13_return: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_i && !trap_i) |=> st_q[ST_IE] == $past(st_q[ST_PIE]) && st_q[ST_PIE]);
endmodule

// File: rtl/mcsr_file.sv
module mcsr_file
  import mcsr_pkg::*;
#(
  parameter int              CAUSE_W   = 6,
  parameter int              VEC_LSB   = 8,
  parameter logic [63:0]     VENDOR_ID = 64'h0,
  parameter logic [63:0]     ARCH_ID   = 64'h19,
  parameter logic [63:0]     IMPL_ID   = 64'h1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         csr_op,
  input  logic [11:0]        csr_addr,
  input  logic [63:0]        csr_wdata,
  output logic [63:0]        csr_rdata,
  output logic               csr_illegal,
  input  logic               retire_i,
  input  logic               trap_i,
  input  logic               trap_irq_i,
  input  logic [CAUSE_W-1:0] trap_code_i,
  input  logic [63:0]        trap_pc_i,
  input  logic               mret_i,
  output logic [63:0]        trap_target_o,
  output logic               timer_irq_o
);
  logic [XLEN-1:0] status_v, epc_v, cause_v, tvec_v;
  logic [XLEN-1:0] cycle_v, instret_v, inhibit_v, timecmp_v;
  logic [XLEN-1:0] scratch_q;
  logic [XLEN-1:0] wval;
  logic            hit;
  logic            ro_write;
  logic            wr;

  always_comb begin
    hit       = 1'b1;
    csr_rdata = '0;
    case (csr_addr)
      A_STATUS:  csr_rdata = status_v;
      A_ISA:     csr_rdata = ISA_VALUE;
      A_EDELEG, A_IDELEG, A_CNTEN, A_TVAL, A_HART: csr_rdata = '0;
      A_TVEC:    csr_rdata = tvec_v;
      A_INHIBIT: csr_rdata = inhibit_v;
      A_SCRATCH: csr_rdata = scratch_q;
      A_EPC:     csr_rdata = epc_v;
      A_CAUSE:   csr_rdata = cause_v;
      A_TIMECMP: csr_rdata = timecmp_v;
      A_CYCLE, A_TIME: csr_rdata = cycle_v;
      A_INSTRET: csr_rdata = instret_v;
      A_VENDOR:  csr_rdata = VENDOR_ID;
      A_ARCH:    csr_rdata = ARCH_ID;
      A_IMPL:    csr_rdata = IMPL_ID;
      default:   hit = 1'b0;
    endcase
  end

  assign ro_write    = (csr_op != OP_READ) && (csr_addr[11:10] == 2'b11);
  assign csr_illegal = !hit || ro_write;
  assign wr          = (csr_op != OP_READ) && !csr_illegal;
  assign wval        = csr_apply(csr_op, csr_rdata, csr_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n)                          scratch_q <= '0;
    else if (wr && csr_addr == A_SCRATCH) scratch_q <= wval;
  end

  mcsr_status #(.CAUSE_W(CAUSE_W)) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .we_status   (wr && csr_addr == A_STATUS),
    .we_epc      (wr && csr_addr == A_EPC),
    .we_cause    (wr && csr_addr == A_CAUSE),
    .wval        (wval),
    .trap_i      (trap_i),
    .trap_irq_i  (trap_irq_i),
    .trap_code_i (trap_code_i),
    .trap_pc_i   (trap_pc_i),
    .mret_i      (mret_i),
    .status_o    (status_v),
    .epc_o       (epc_v),
    .cause_o     (cause_v)
  );

  mcsr_tvec #(.CAUSE_W(CAUSE_W), .VEC_LSB(VEC_LSB)) u_tvec (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (wr && csr_addr == A_TVEC),
    .wval        (wval),
    .trap_irq_i  (trap_irq_i),
    .trap_code_i (trap_code_i),
    .tvec_o      (tvec_v),
    .target_o    (trap_target_o)
  );

  mcsr_counters u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .retire_i    (retire_i),
    .we_cycle    (wr && csr_addr == A_CYCLE),
    .we_instret  (wr && csr_addr == A_INSTRET),
    .we_inhibit  (wr && csr_addr == A_INHIBIT),
    .we_cmp      (wr && csr_addr == A_TIMECMP),
    .wval        (wval),
    .cycle_o     (cycle_v),
    .instret_o   (instret_v),
    .inhibit_o   (inhibit_v),
    .timecmp_o   (timecmp_v),
    .timer_irq_o (timer_irq_o)
  );

  // R5: a flagged access leaves the scratch register unchanged
  a_r5_no_illegal_write: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |=> $stable(scratch_q));
  // R1: identity register reads never change
  a_r1_isa_const: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == A_ISA) |-> csr_rdata == ISA_VALUE && !(csr_illegal && csr_op == 2'd0));
endmodule

// File: tb/mcsr_file_tb.sv
module mcsr_file_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  csr_op = 2'd0;
  logic [11:0] csr_addr = 12'h300;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        csr_illegal;
  logic        retire_i = 1'b0;
  logic        trap_i = 1'b0;
  logic        trap_irq_i = 1'b0;
  logic [5:0]  trap_code_i = '0;
  logic [63:0] trap_pc_i = '0;
  logic        mret_i = 1'b0;
  logic [63:0] trap_target_o;
  logic        timer_irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mcsr_file u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .csr_op        (csr_op),
    .csr_addr      (csr_addr),
    .csr_wdata     (csr_wdata),
    .csr_rdata     (csr_rdata),
    .csr_illegal   (csr_illegal),
    .retire_i      (retire_i),
    .trap_i        (trap_i),
    .trap_irq_i    (trap_irq_i),
    .trap_code_i   (trap_code_i),
    .trap_pc_i     (trap_pc_i),
    .mret_i        (mret_i),
    .trap_target_o (trap_target_o),
    .timer_irq_o   (timer_irq_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // access lands on the edge between two falling edges
  task automatic acc(input logic [1:0] op, input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_op = op; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_op = 2'd0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] v);
    csr_op = 2'd0; csr_addr = a;
    #1;
    v = csr_rdata;
  endtask

  task automatic t_reset;
    logic [63:0] v;
    rd(12'h300, v); check("R2 status at reset", v, 64'h0000_0002_0000_1800);
    rd(12'h301, v); check("R1 isa", v, 64'h8000_0000_0000_1504);
    rd(12'hF14, v); check("R1 hart id", v, 64'h0);
    rd(12'hF12, v); check("R1 arch id", v, 64'h19);
    rd(12'hF13, v); check("R1 impl id", v, 64'h1);
    check("R11 no timer irq at reset", {63'b0, timer_irq_o}, 64'h0);
  endtask

  task automatic t_status_mask;
    logic [63:0] v;
    acc(2'd1, 12'h300, '1);
    rd(12'h300, v); check("R2 status write ones", v, 64'h0000_0002_0022_1888);
    acc(2'd1, 12'h300, '0);
    rd(12'h300, v); check("R2 status write zero", v, 64'h0000_0002_0000_0000);
  endtask

  task automatic t_zero_regs;
    logic [63:0] v;
    acc(2'd1, 12'h302, '1);
    rd(12'h302, v); check("R3 exc delegation", v, 64'h0);
    acc(2'd1, 12'h306, '1);
    rd(12'h306, v); check("R3 counter enable", v, 64'h0);
    csr_op = 2'd1; csr_addr = 12'h343; #1;
    check("R3 trap value write not flagged", {63'b0, csr_illegal}, 64'h0);
    csr_op = 2'd0;
    rd(12'h343, v); check("R3 trap value", v, 64'h0);
  endtask

  task automatic t_ops;
    logic [63:0] v;
    acc(2'd1, 12'h340, 64'hF0);
    rd(12'h340, v); check("R4 write", v, 64'hF0);
    acc(2'd2, 12'h340, 64'h0F);
    rd(12'h340, v); check("R4 set", v, 64'hFF);
    acc(2'd3, 12'h340, 64'h3C);
    rd(12'h340, v); check("R4 clear", v, 64'hC3);
  endtask

  task automatic t_illegal;
    logic [63:0] v;
    rd(12'h7B0, v); check("R5 unknown address", {63'b0, csr_illegal}, 64'h1);
    rd(12'h340, v); check("R5 known address", {63'b0, csr_illegal}, 64'h0);
    @(negedge clk); csr_op = 2'd1; csr_addr = 12'hF14; #1;
    check("R5 write to read-only", {63'b0, csr_illegal}, 64'h1);
    acc(2'd1, 12'h301, 64'h0);
    rd(12'h301, v); check("R5 isa unchanged", v, 64'h8000_0000_0000_1504);
    acc(2'd1, 12'h7B0, 64'h55);
    rd(12'h340, v); check("R5 scratch untouched", v, 64'hC3);
  endtask

  task automatic t_tvec;
    logic [63:0] v;
    acc(2'd1, 12'h305, 64'h8000_01FD);
    rd(12'h305, v); check("R6 vectored aligned", v, 64'h8000_0101);
    trap_irq_i = 1'b1; trap_code_i = 6'd7; #1;
    check("R7 vectored irq target", trap_target_o, 64'h8000_011C);
    trap_irq_i = 1'b0; trap_code_i = 6'd2; #1;
    check("R7 vectored exc target", trap_target_o, 64'h8000_0100);
    acc(2'd1, 12'h305, 64'h8000_00FC);
    rd(12'h305, v); check("R6 direct", v, 64'h8000_00FC);
    trap_irq_i = 1'b1; trap_code_i = 6'd7; #1;
    check("R7 direct irq target", trap_target_o, 64'h8000_00FC);
    trap_irq_i = 1'b0;
    acc(2'd1, 12'h305, 64'h9000_0002);
    rd(12'h305, v); check("R6 reserved mode kept", v, 64'h9000_0000);
  endtask

  task automatic t_cycle;
    logic [63:0] v, w;
    acc(2'd1, 12'hB00, 64'd100);
    rd(12'hB00, v); check("R8 write wins", v, 64'd100);
    rd(12'hFC0, w); check("R8 timer alias", w, v);
    @(negedge clk);
    rd(12'hB00, v); check("R8 increments", v, 64'd101);
    acc(2'd1, 12'h320, '1);
    rd(12'h320, v); check("R10 inhibit bits", v, 64'h5);
    rd(12'hB00, v);
    @(negedge clk); @(negedge clk);
    rd(12'hB00, w); check("R8 inhibited holds", w, v);
  endtask

  task automatic t_instret;
    logic [63:0] v;
    acc(2'd1, 12'h320, 64'h0);
    acc(2'd1, 12'hB02, 64'd5);
    @(negedge clk); retire_i = 1'b1;
    repeat (3) @(negedge clk);
    retire_i = 1'b0;
    rd(12'hB02, v); check("R9 three retires", v, 64'd8);
    @(negedge clk); retire_i = 1'b1; csr_op = 2'd1; csr_addr = 12'hB02; csr_wdata = 64'd20;
    @(negedge clk); retire_i = 1'b0; csr_op = 2'd0;
    rd(12'hB02, v); check("R9 write wins retire", v, 64'd20);
    acc(2'd1, 12'h320, 64'h4);
    @(negedge clk); retire_i = 1'b1;
    repeat (2) @(negedge clk);
    retire_i = 1'b0;
    rd(12'hB02, v); check("R9 inhibited", v, 64'd20);
  endtask

  task automatic t_timer;
    acc(2'd1, 12'h320, 64'h1);
    acc(2'd1, 12'hB00, 64'd1000);
    acc(2'd1, 12'h7C0, 64'd1001);
    check("R11 below compare", {63'b0, timer_irq_o}, 64'h0);
    acc(2'd1, 12'h7C0, 64'd1000);
    check("R11 equal compare", {63'b0, timer_irq_o}, 64'h1);
    acc(2'd1, 12'h7C0, 64'd999);
    check("R11 above compare", {63'b0, timer_irq_o}, 64'h1);
  endtask

  task automatic t_trap;
    logic [63:0] v;
    acc(2'd1, 12'h300, 64'h8);
    @(negedge clk);
    trap_i = 1'b1; trap_irq_i = 1'b1; trap_code_i = 6'd7; trap_pc_i = 64'h4000_0007;
    csr_op = 2'd1; csr_addr = 12'h341; csr_wdata = 64'h1234;
    @(negedge clk);
    trap_i = 1'b0; trap_irq_i = 1'b0; csr_op = 2'd0;
    rd(12'h300, v); check("R12 status on trap", v, 64'h0000_0002_0000_1880);
    rd(12'h341, v); check("R12 pc over write", v, 64'h4000_0006);
    rd(12'h342, v); check("R12 cause", v, 64'h8000_0000_0000_0007);
    @(negedge clk); mret_i = 1'b1;
    @(negedge clk); mret_i = 1'b0;
    rd(12'h300, v); check("R13 status on return", v, 64'h0000_0002_0000_1888);
    acc(2'd1, 12'h342, '1);
    rd(12'h342, v); check("R14 cause mask", v, 64'h8000_0000_0000_003F);
    acc(2'd1, 12'h341, '1);
    rd(12'h341, v); check("R14 pc even", v, 64'hFFFF_FFFF_FFFF_FFFE);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_status_mask();
    t_zero_regs();
    t_ops();
    t_illegal();
    t_tvec();
    t_cycle();
    t_instret();
    t_timer();
    t_trap();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule